// File: doc/BRIEF.md
# Banked Serial Port Register Front End

This block is the byte-wide register file that sits between a host bus and the transmit and receive paths of a serial port. A 3-bit address with separate read and write strobes reaches a line control byte, a FIFO enable bit, a receive interrupt enable bit and a 16-bit baud divisor. The divisor shares the two lowest addresses with the data port and the interrupt enable register. Bit 7 of the line control byte picks which of the two banks those addresses reach.

The block also derives two timing strobes from the divisor. One is an oversampling tick that fires once every divisor clocks. The other is a bit-rate tick that fires once every sixteen oversampling ticks. To get a given bit rate, software writes divisor = ceil(clock_hz / (16 x baud)). For example, 592 (0x0250) gives 2400 baud from a 22.729 MHz clock. The shifters and FIFOs live outside this block. It hands them a one-cycle push strobe with a byte on data writes and a one-cycle pop strobe on data reads. It raises an interrupt while received data waits and the interrupt is enabled.

Top module: `serial_regbank`

## Requirements
- R1: After reset, the line control byte, the interrupt enable bit, the FIFO enable bit and the divisor are all 0, and `tx_push`, `rx_pop`, `tick16`, `baud_tick` and `irq` are low.
- R2: Offset 3 holds the full 8-bit line control byte and reads back what was written. `word_len` always shows its bits 1:0, where 2'b11 means 8-bit words.
- R3: While line control bit 7 is 1, offset 0 reads and writes the divisor low byte and offset 1 reads and writes the divisor high byte.
- R4: While line control bit 7 is 0, a write to offset 0 gives `tx_push` high for exactly the cycle after the write, with `tx_byte` equal to the written byte. A write to offset 0 while bit 7 is 1 gives no push.
- R5: While line control bit 7 is 0, a read of offset 0 returns `rx_byte` on `rdata` in the cycle after the read strobe, with `rx_pop` high for that one cycle. A read of offset 0 while bit 7 is 1 gives no pop.
- R6: While line control bit 7 is 0, offset 1 holds the receive interrupt enable in bit 0, and its bits 7:1 read 0. Writing it leaves the divisor unchanged.
- R7: A write to offset 2 stores bit 0 as the FIFO enable, which drives `fifo_en`. A read of offset 2 returns {7'b0, fifo_en}.
- R8: `irq` is high exactly when the receive interrupt enable bit is 1 and `rx_ready` is 1.
- R9: With a non-zero divisor D, `tick16` is a one-cycle pulse that repeats every D cycles. A write to either divisor byte restarts the count, and the first pulse comes D cycles after that write.
- R10: With a non-zero divisor, `baud_tick` pulses together with every 16th `tick16` pulse, so its period is 16 x D cycles.
- R11: With a divisor of 0, `tick16` and `baud_tick` stay low.
- R12: Offsets 4 to 7 read as 0, and writes to them change no register.
- R13: `rdata` changes only in the cycle after a read strobe and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| rx_byte | input | 8 | Byte at the head of the receive FIFO |
| rx_ready | input | 1 | Receive FIFO holds data |
| rx_pop | output | 1 | One-cycle pop toward the receive FIFO |
| tx_push | output | 1 | One-cycle push toward the transmit FIFO |
| tx_byte | output | 8 | Byte carried with `tx_push` |
| word_len | output | 2 | Word length field of line control |
| fifo_en | output | 1 | FIFO enable |
| irq | output | 1 | Receive data interrupt |
| tick16 | output | 1 | Oversampling tick |
| baud_tick | output | 1 | Bit-rate tick |

## Verification
Some rules hold on every cycle, and the embedded assertions check these:
- a push or pop only follows the matching strobe at offset 0 with the bank bit clear;
- the interrupt never rises without `rx_ready`;
- a zero divisor stays silent;
- a bit-rate tick never appears without an oversampling tick.

Other behaviour can only be seen through the bench's scenarios:
- bank switching, with the same offsets returning different registers;
- the actual tick spacing of D and 16 x D cycles, and the restart when a divisor byte is written;
- readback of the 592 divisor;
- the fact that writes to offsets 4 to 7 and interrupt-enable writes leave the other registers untouched.

// File: rtl/serial_regbank.sv
module serial_regbank #(
  parameter int DW   = 8,
  parameter int AW   = 3,
  parameter int OSR  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_ready,
  output logic          rx_pop,
  output logic          tx_push,
  output logic [DW-1:0] tx_byte,
  output logic [1:0]    word_len,
  output logic          fifo_en,
  output logic          irq,
  output logic          tick16,
  output logic          baud_tick
);
  localparam int DIVW = 2*DW;
  localparam int SUBW = $clog2(OSR);
  localparam logic [SUBW-1:0] SUB_LAST = SUBW'(OSR-1);

  logic [DW-1:0]   lcr;
  logic            rx_ie;
  logic            fen;
  logic [DIVW-1:0] div;
  logic [DIVW-1:0] cnt;
  logic [SUBW-1:0] sub;

  wire bank = lcr[7];
  wire sel0 = addr == AW'(0);
  wire sel1 = addr == AW'(1);
  wire sel2 = addr == AW'(2);
  wire sel3 = addr == AW'(3);

  wire wr_lo  = wr_en & sel0 & bank;
  wire wr_hi  = wr_en & sel1 & bank;
  wire wr_thr = wr_en & sel0 & ~bank;
  wire wr_ier = wr_en & sel1 & ~bank;
  wire rd_rbr = rd_en & sel0 & ~bank;

  logic [DIVW-1:0] div_nx;
  always_comb begin
    div_nx = div;
    if (wr_lo) div_nx[DW-1:0]    = wdata;
    if (wr_hi) div_nx[DIVW-1:DW] = wdata;
  end

  wire div_wr = wr_lo | wr_hi;
  wire fire   = (div != '0) && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr   <= '0;
      rx_ie <= 1'b0;
      fen   <= 1'b0;
      div   <= '0;
    end else if (wr_en) begin
      if (sel3)   lcr   <= wdata;
      if (sel2)   fen   <= wdata[0];
      if (wr_ier) rx_ie <= wdata[0];
      if (div_wr) div   <= div_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      sub       <= '0;
      tick16    <= 1'b0;
      baud_tick <= 1'b0;
    end else begin
      tick16    <= fire & ~div_wr;
      baud_tick <= fire & ~div_wr & (sub == SUB_LAST);
      if (div_wr) begin
        cnt <= (div_nx == '0) ? '0 : div_nx - 1'b1;
        sub <= '0;
      end else if (fire) begin
        cnt <= div - 1'b1;
        sub <= sub + 1'b1;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  logic [DW-1:0] rmux;
  always_comb begin
    unique case (addr)
      AW'(0):  rmux = bank ? div[DW-1:0] : rx_byte;
      AW'(1):  rmux = bank ? div[DIVW-1:DW] : {{(DW-1){1'b0}}, rx_ie};
      AW'(2):  rmux = {{(DW-1){1'b0}}, fen};
      AW'(3):  rmux = lcr;
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata   <= '0;
      rx_pop  <= 1'b0;
      tx_push <= 1'b0;
      tx_byte <= '0;
    end else begin
      rx_pop  <= rd_rbr;
      tx_push <= wr_thr;
      if (rd_en)  rdata   <= rmux;
      if (wr_thr) tx_byte <= wdata;
    end
  end

  assign word_len = lcr[1:0];
  assign fifo_en  = fen;
  assign irq      = rx_ie & rx_ready;

  p_push_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |-> ($past(wr_en) && $past(addr) == AW'(0) && !$past(lcr[7])));
  p_push_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |-> tx_byte == $past(wdata));
  p_pop_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> ($past(rd_en) && $past(addr) == AW'(0) && !$past(lcr[7])));
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> rx_ready);
  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (div == '0 && $past(div) == '0) |-> !tick16 && !baud_tick);
  p_baud_sync_r10: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> tick16);
  p_rdata_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en) |-> $stable(rdata));
endmodule

// File: tb/tb_serial_regbank.sv
module tb_serial_regbank;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [2:0] addr = 0;
  logic       wr_en = 0, rd_en = 0;
  logic [7:0] wdata = 0, rx_byte = 0;
  logic       rx_ready = 0;
  logic [7:0] rdata, tx_byte;
  logic       rx_pop, tx_push, fifo_en, irq, tick16, baud_tick;
  logic [1:0] word_len;

  serial_regbank dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .rx_byte(rx_byte),
    .rx_ready(rx_ready), .rx_pop(rx_pop), .tx_push(tx_push), .tx_byte(tx_byte),
    .word_len(word_len), .fifo_en(fifo_en), .irq(irq), .tick16(tick16),
    .baud_tick(baud_tick));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int pops = 0;
  logic [7:0] rd_q[$];
  string      rd_tag[$];
  logic [7:0] tx_q[$];
  logic       rd_d = 0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    rd_q.push_back(exp); rd_tag.push_back(tag);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0;
  endtask

  always @(posedge clk) rd_d <= rd_en;

  always @(negedge clk) begin
    if (rd_d) begin
      if (rd_q.size() == 0) check("R13 unexpected read", 1, 0);
      else check(rd_tag.pop_front(), rdata, rd_q.pop_front());
    end
    if (tx_push) begin
      if (tx_q.size() == 0) check("R4 unexpected push", 1, 0);
      else check("R4 push byte", tx_byte, tx_q.pop_front());
    end
    if (rx_pop) pops++;
  end

  task automatic gap(input int expect_spacing, input string tag, input bit use_baud);
    int n = 0;
    do begin @(negedge clk); n++; end while (!(use_baud ? baud_tick : tick16) && n < 2000);
    n = 0;
    do begin @(negedge clk); n++; end while (!(use_baud ? baud_tick : tick16) && n < 2000);
    check(tag, n, expect_spacing);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int base;
    int tcount;
    repeat (3) @(negedge clk);
    check("R1 tx_push", tx_push, 0);
    check("R1 outputs", {rx_pop, tick16, baud_tick, irq, fifo_en, word_len}, 0);
    rst_n = 1;
    rd(3, 8'h00, "R1 lcr reset");
    rd(1, 8'h00, "R1 ier reset");
    repeat (20) @(negedge clk);
    check("R11 no tick at reset", tick16 | baud_tick, 0);

    wr(3, 8'h03);
    check("R2 word_len", word_len, 3);
    rd(3, 8'h03, "R2 lcr readback");
    wr(3, 8'h5a);
    rd(3, 8'h5a, "R2 lcr full byte");
    check("R2 word_len 2", word_len, 2);
    wr(3, 8'h03);

    tx_q.push_back(8'hc3);
    wr(0, 8'hc3);
    tx_q.push_back(8'h00);
    wr(0, 8'h00);
    @(negedge clk);
    check("R4 push queue drained", tx_q.size(), 0);

    rx_byte = 8'h9e;
    base = pops;
    rd(0, 8'h9e, "R5 rbr data");
    @(negedge clk);
    check("R5 one pop", pops - base, 1);

    wr(1, 8'hff);
    rd(1, 8'h01, "R6 ier bit0 only");
    wr(2, 8'hff);
    check("R7 fifo_en", fifo_en, 1);
    rd(2, 8'h01, "R7 fcr read");
    wr(2, 8'h00);
    check("R7 fifo_en off", fifo_en, 0);

    rx_ready = 1; #1;
    check("R8 irq on", irq, 1);
    wr(1, 8'h00);
    check("R8 irq disabled", irq, 0);
    rx_ready = 0; wr(1, 8'h01); #1;
    check("R8 irq no data", irq, 0);
    rx_ready = 1; #1;
    check("R8 irq again", irq, 1);
    rx_ready = 0;

    wr(3, 8'h83);
    wr(0, 8'h50);
    wr(1, 8'h02);
    base = pops;
    rd(0, 8'h50, "R3 divisor low");
    rd(1, 8'h02, "R3 divisor high");
    @(negedge clk);
    check("R5 no pop with bank bit", pops - base, 0);
    @(negedge clk);
    check("R4 no push with bank bit", tx_q.size(), 0);

    wr(3, 8'h03);
    wr(1, 8'h00);
    rd(1, 8'h00, "R6 ier cleared");
    wr(3, 8'h83);
    rd(0, 8'h50, "R6 divisor low untouched");
    rd(1, 8'h02, "R6 divisor high untouched");

    wr(4, 8'hff); wr(7, 8'hff);
    rd(5, 8'h00, "R12 offset5 reads 0");
    rd(7, 8'h00, "R12 offset7 reads 0");
    rd(3, 8'h83, "R12 lcr untouched");
    rd(0, 8'h50, "R12 divisor untouched");

    wr(0, 8'h03);
    wr(1, 8'h00);
    n = 0;
    while (!tick16 && n < 100) begin @(negedge clk); n++; end
    check("R9 first tick after write", n, 3);
    gap(3, "R9 tick16 spacing", 0);
    gap(3, "R9 tick16 spacing again", 0);
    gap(48, "R10 baud spacing", 1);
    tcount = 0; n = 0;
    do begin @(negedge clk); if (tick16) tcount++; n++; end while (!baud_tick && n < 500);
    check("R10 tick16 per baud", tcount, 16);

    wr(0, 8'h05);
    n = 0;
    while (!tick16 && n < 100) begin @(negedge clk); n++; end
    check("R9 restart on low write", n, 5);

    wr(0, 8'h00);
    @(negedge clk);
    tcount = 0;
    repeat (300) begin @(negedge clk); if (tick16 || baud_tick) tcount++; end
    check("R11 zero divisor silent", tcount, 0);

    wr(3, 8'h03);
    rx_byte = 8'h11;
    rd(2, 8'h00, "R13 read fcr");
    rx_byte = 8'h77;
    repeat (4) @(negedge clk);
    check("R13 rdata held", rdata, 8'h00);

    repeat (3) @(negedge clk);
    check("R13 read queue drained", rd_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule